// File: doc/BRIEF.md
# Read-Started ADC Sample Sequencer

This block is the host-side controller for a 12-bit sampling converter whose conversions are launched by the read strobe itself. The host never polls a busy line. Each converting read returns the result of the conversion before it and starts the next one. The controller drives the active-low chip-select and read strobes and a high-byte-enable line. It paces the reads so the converter always has enough time, and it presents each assembled 12-bit sample with a one-cycle valid pulse.

There are two bus arrangements. In parallel mode all twelve data lines are read in one access. In byte mode only the low eight lines are used, and a sample is built from two reads. The first read has high-byte-enable raised: it returns the top four bits on the lowest four lines and leaves the converter alone. The second read has high-byte-enable low: it returns the low eight bits and launches the next conversion. The converter holds no useful result after reset, so the first sample of a run is preceded by a priming read whose data is thrown away.

Each pulse on the request input asks for one sample. Requests that arrive while the controller is busy, or before the spacing rule allows another read, are counted and served in turn. The mode input is taken only when the controller picks up a new request.

Top module: `adc_rom_seq`

## Requirements
- R1: While reset is held and just after it, `cs_n_o` and `rd_n_o` are 1, `hben_o` is 0, `valid_o` is 0 and `result_o` is 0.
- R2: `cs_n_o` is low in every cycle that `rd_n_o` is low. It also falls at least one cycle before `rd_n_o` falls and rises at least one cycle after `rd_n_o` rises.
- R3: Every read holds `rd_n_o` low for exactly `RD_CYC` clock cycles. `data_i` is captured in the last of those cycles.
- R4: In parallel mode (`byte_mode_i` = 1'b0), a sample with the controller primed takes a single read with `hben_o` = 0, and `result_o` equals all twelve bits of `data_i`.
- R5: Between the falling edges of two successive reads that have `hben_o` = 0, at least `CONV_CYC + GAP_CYC` cycles pass.
- R6: The first sample after reset is preceded by an extra read with `hben_o` = 0. That read returns no result and raises no valid pulse.
- R7: In byte mode (`byte_mode_i` = 1'b1), a primed sample takes a read with `hben_o` = 1 and then a read with `hben_o` = 0. `data_i[3:0]` from the first read becomes `result_o[11:8]` and `data_i[7:0]` from the second becomes `result_o[7:0]`. The `hben_o` = 1 read falls at least `CONV_CYC` cycles after the last converting read fell, and it does not count as a converting read.
- R8: In byte mode straight after reset, the first read of a sample has `hben_o` = 0 and is followed by the two reads of R7. One valid pulse results.
- R9: `valid_o` is high for one cycle per sample, and `result_o` holds its value until the next sample.
- R10: Every request pulse produces exactly one valid pulse, including pulses that arrive while a sample is in progress.
- R11: `byte_mode_i` is sampled only when a request is taken up. Changing it during a sample does not alter that sample's read pattern.
- R12: `hben_o` is 0 whenever `cs_n_o` is 1, and it stays constant while `rd_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle pulse asking for a sample |
| byte_mode_i | input | 1 | 1 = eight-line two-byte reads, 0 = twelve-line parallel reads |
| data_i | input | 12 | Converter data lines |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| hben_o | output | 1 | High-byte enable; high selects the top nibble and suppresses a conversion start |
| result_o | output | 12 | Last assembled sample |
| valid_o | output | 1 | One-cycle pulse marking a new `result_o` |

## Verification
The assertions check the following on every cycle: chip-select encloses the read strobe, converting reads never start early against the elapsed-cycle timer, high-byte reads wait out a conversion, high-byte-enable stays steady and inside chip-select, and valid is a single-cycle pulse. Only the bench scenarios can show the rest. That covers the priming read after reset in each mode, the read count and read kind per sample, correct assembly of the two bytes against a converter model, requests queued during a sample, and a mode change in mid-sample that must be ignored.

// File: rtl/adc_rom_seq_pkg.sv
package adc_rom_seq_pkg;

  localparam int SAMPLE_W   = 12;
  localparam int NIBBLE_W   = 4;
  localparam int LOBYTE_W   = 8;
  // cycles from a launch decision to the strobe's falling edge
  localparam int LAUNCH_LAT = 2;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRIME,
    PH_HIGH,
    PH_DATA
  } phase_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HOLD
  } strobe_t;

  function automatic int spacing_cycles(input int conv_cyc, input int gap_cyc);
    return conv_cyc + gap_cyc;
  endfunction

  function automatic logic launch_ok(input int elapsed, input int need);
    return (elapsed + LAUNCH_LAT) >= need;
  endfunction

  function automatic logic [SAMPLE_W-1:0] join_bytes(input logic [NIBBLE_W-1:0] hi,
                                                     input logic [LOBYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic phase_t first_phase(input logic primed, input logic byte_m);
    if (!primed)     return PH_PRIME;
    else if (byte_m) return PH_HIGH;
    else             return PH_DATA;
  endfunction

  function automatic phase_t after_read(input phase_t p, input logic byte_m);
    case (p)
      PH_PRIME: return byte_m ? PH_HIGH : PH_DATA;
      PH_HIGH:  return PH_DATA;
      default:  return PH_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/adc_rom_seq_strobe.sv
module adc_rom_seq_strobe
  import adc_rom_seq_pkg::*;
#(
  parameter int RD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic hben_req_i,
  output logic cs_n_o,
  output logic rd_n_o,
  output logic hben_o,
  output logic sample_o,
  output logic conv_o,
  output logic done_o,
  output logic busy_o
);

  localparam int CW = (RD_CYC > 1) ? $clog2(RD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(RD_CYC - 1);

  strobe_t        st;
  logic [CW-1:0]  cnt;
  logic           hb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      hb_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (go_i) begin
            st   <= ST_SETUP;
            hb_q <= hben_req_i;
          end
        end
        ST_SETUP: begin
          st  <= ST_LOW;
          cnt <= '0;
        end
        ST_LOW: begin
          if (cnt == LAST) st <= ST_HOLD;
          else             cnt <= cnt + 1'b1;
        end
        default: begin
          st   <= ST_IDLE;
          hb_q <= 1'b0;
        end
      endcase
    end
  end

  assign cs_n_o   = (st == ST_IDLE);
  assign rd_n_o   = (st != ST_LOW);
  assign hben_o   = hb_q && (st != ST_IDLE);
  assign sample_o = (st == ST_LOW) && (cnt == LAST);
  assign conv_o   = (st == ST_LOW) && (cnt == '0) && !hb_q;
  assign done_o   = (st == ST_HOLD);
  assign busy_o   = (st != ST_IDLE);

endmodule

// File: rtl/adc_rom_seq_timer.sv
module adc_rom_seq_timer #(
  parameter int LIMIT = 50,
  parameter int EL_W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output logic [EL_W-1:0] elapsed_o
);

  localparam logic [EL_W-1:0] SAT = EL_W'(LIMIT);

  // cycles since the last conversion launch, saturating at LIMIT
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                elapsed_o <= SAT;
    else if (start_i)          elapsed_o <= EL_W'(1);
    else if (elapsed_o < SAT)  elapsed_o <= elapsed_o + 1'b1;
  end

endmodule

// File: rtl/adc_rom_seq_pending.sv
module adc_rom_seq_pending #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  output logic any_o
);

  logic [PEND_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   count <= '0;
    else if (push_i && !pop_i && (count != '1))   count <= count + 1'b1;
    else if (!push_i && pop_i && (count != '0))   count <= count - 1'b1;
  end

  assign any_o = (count != '0);

endmodule

// File: rtl/adc_rom_seq.sv
module adc_rom_seq
  import adc_rom_seq_pkg::*;
#(
  parameter int CONV_CYC = 20,
  parameter int GAP_CYC  = 30,
  parameter int RD_CYC   = 3,
  parameter int PEND_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                byte_mode_i,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic                cs_n_o,
  output logic                rd_n_o,
  output logic                hben_o,
  output logic [SAMPLE_W-1:0] result_o,
  output logic                valid_o
);

  localparam int SPACE = spacing_cycles(CONV_CYC, GAP_CYC);
  localparam int EL_W  = $clog2(SPACE + 1);

  phase_t                phase;
  logic                  launched;
  logic                  primed;
  logic                  mode_q;
  logic [NIBBLE_W-1:0]   hi_q;

  logic                  go;
  logic                  hben_req;
  logic                  pop;
  logic                  pend_any;
  logic                  time_ok;
  int                    need_cyc;

  logic                  samp_edge;
  logic                  conv_start;
  logic                  read_done;
  logic                  strobe_busy;
  logic [EL_W-1:0]       elapsed;

  adc_rom_seq_pending #(.PEND_W(PEND_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (req_i),
    .pop_i  (pop),
    .any_o  (pend_any)
  );

  adc_rom_seq_timer #(.LIMIT(SPACE), .EL_W(EL_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (conv_start),
    .elapsed_o (elapsed)
  );

  adc_rom_seq_strobe #(.RD_CYC(RD_CYC)) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (go),
    .hben_req_i (hben_req),
    .cs_n_o     (cs_n_o),
    .rd_n_o     (rd_n_o),
    .hben_o     (hben_o),
    .sample_o   (samp_edge),
    .conv_o     (conv_start),
    .done_o     (read_done),
    .busy_o     (strobe_busy)
  );

  always_comb begin
    hben_req = (phase == PH_HIGH);
    need_cyc = hben_req ? CONV_CYC : SPACE;
    time_ok  = launch_ok(int'(elapsed), need_cyc);
    pop      = (phase == PH_IDLE) && pend_any && !strobe_busy;
    go       = (phase != PH_IDLE) && !launched && !strobe_busy && time_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      launched <= 1'b0;
      primed   <= 1'b0;
      mode_q   <= 1'b0;
      hi_q     <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (conv_start) primed <= 1'b1;

      if (phase == PH_IDLE) begin
        if (pop) begin
          mode_q   <= byte_mode_i;
          launched <= 1'b0;
          phase    <= first_phase(primed, byte_mode_i);
        end
      end else if (go) begin
        launched <= 1'b1;
      end else if (launched && read_done) begin
        launched <= 1'b0;
        phase    <= after_read(phase, mode_q);
      end

      if (samp_edge && (phase == PH_HIGH)) hi_q <= data_i[NIBBLE_W-1:0];
      if (samp_edge && (phase == PH_DATA)) begin
        result_o <= mode_q ? join_bytes(hi_q, data_i[LOBYTE_W-1:0]) : data_i;
        valid_o  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_rom_seq_chk.sv
module adc_rom_seq_chk #(
  parameter int CONV_CYC = 20,
  parameter int SPACE    = 50,
  parameter int EL_W     = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            rd_n,
  input logic            hben,
  input logic            valid,
  input logic            conv_start,
  input logic [EL_W-1:0] elapsed
);

  a_r2_cs_covers_rd: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);

  a_r2_cs_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(!cs_n));

  a_r2_cs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> !cs_n);

  a_r5_launch_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (int'(elapsed) >= SPACE));

  a_r5_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> ($fell(rd_n) && !hben));

  a_r7_high_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) && hben) |-> (int'(elapsed) >= CONV_CYC));

  a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r12_hben_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !$fell(rd_n)) |-> $stable(hben));

  a_r12_hben_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    hben |-> !cs_n);

endmodule

bind adc_rom_seq adc_rom_seq_chk #(
  .CONV_CYC (CONV_CYC),
  .SPACE    (SPACE),
  .EL_W     (EL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n_o),
  .rd_n       (rd_n_o),
  .hben       (hben_o),
  .valid      (valid_o),
  .conv_start (conv_start),
  .elapsed    (elapsed)
);

// File: tb/sim_adc_rom_seq.sv
module sim_adc_rom_seq;

  localparam int CONV  = 20;
  localparam int GAP   = 30;
  localparam int RDW   = 3;
  localparam int SPACE = CONV + GAP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        bmode = 1'b0;
  logic [11:0] bus = 12'hFFF;
  logic        u_cs, u_rd, u_hben, u_valid;
  logic [11:0] u_res;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  adc_rom_seq #(.CONV_CYC(CONV), .GAP_CYC(GAP), .RD_CYC(RDW), .PEND_W(4)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .byte_mode_i (bmode),
    .data_i      (bus),
    .cs_n_o      (u_cs),
    .rd_n_o      (u_rd),
    .hben_o      (u_hben),
    .result_o    (u_res),
    .valid_o     (u_valid)
  );

  function automatic logic [11:0] sample_val(input int k);
    return 12'(32'h5A3 + k * 32'h2E9);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model and strobe monitor
  logic [11:0] conv_val = 12'hBAD;
  int conv_cnt, n_conv, n_hi, n_valid, cyc, last_start, low_run;
  bit has_start, prev_rd, prev_cs, prev_valid, fall_hben, first_seen, first_hben;

  always @(negedge clk) begin
    if (!rst_n) begin
      conv_cnt = 0; has_start = 0; low_run = 0; cyc = 0;
      prev_rd = 1; prev_cs = 1; prev_valid = 0; first_seen = 0;
    end else begin
      cyc++;
      if (!u_rd && prev_rd) begin
        check(!prev_cs, "R2 cs setup", int'(prev_cs), 0);
        if (!first_seen) begin first_seen = 1; first_hben = u_hben; end
        if (!u_hben) begin
          if (has_start) check(cyc - last_start >= SPACE, "R5 spacing", cyc - last_start, SPACE);
          bus = conv_val;
          conv_val = sample_val(conv_cnt);
          conv_cnt++; n_conv++;
          last_start = cyc; has_start = 1;
        end else begin
          if (has_start) check(cyc - last_start >= CONV, "R7 high read wait", cyc - last_start, CONV);
          bus = {conv_val[11:8], 4'h0, conv_val[11:8]};
          n_hi++;
        end
        fall_hben = u_hben;
      end
      if (!u_rd) begin
        low_run++;
        if (u_cs) check(0, "R2 cs during read", 1, 0);
      end
      if (u_rd && !prev_rd) begin
        check(!u_cs, "R2 cs hold", int'(u_cs), 0);
        check(low_run == RDW, "R3 strobe width", low_run, RDW);
        check(u_hben == fall_hben, "R12 hben steady", int'(u_hben), int'(fall_hben));
        low_run = 0;
        bus = 12'hFFF;
      end
      if (u_cs && u_hben) check(0, "R12 hben outside cs", 1, 0);
      if (u_valid) begin
        n_valid++;
        check(conv_cnt >= 2 && u_res == sample_val(conv_cnt - 2), "R4/R7 result",
              int'(u_res), int'(sample_val(conv_cnt - 2)));
        check(!prev_valid, "R9 single-cycle valid", 1, 0);
      end
      prev_rd = u_rd; prev_cs = u_cs; prev_valid = u_valid;
    end
  end

  task automatic pulse_req();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
  endtask

  task automatic wait_valids(input int target, input string tag);
    for (int i = 0; i < 3000 && n_valid < target; i++) @(negedge clk);
    check(n_valid >= target, tag, n_valid, target);
    repeat (SPACE + 20) @(negedge clk);
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 1'b0; bmode = mode;
    repeat (4) @(negedge clk);
    check(u_cs && u_rd && !u_hben && !u_valid && u_res == 12'h0, "R1 reset outputs",
          {u_cs, u_rd, u_hben, u_valid}, 4'b1100);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(u_cs && u_rd && !u_hben && !u_valid, "R1 after release",
          {u_cs, u_rd, u_hben, u_valid}, 4'b1100);
  endtask

  task automatic t_parallel_cold();
    int c0 = n_conv, h0 = n_hi, v0 = n_valid;
    logic [11:0] held;
    pulse_req();
    for (int i = 0; i < 3000 && n_valid == v0; i++) @(negedge clk);
    held = u_res;
    repeat (5) @(negedge clk);
    check(u_res == held, "R9 result held", int'(u_res), int'(held));
    repeat (SPACE + 20) @(negedge clk);
    check(n_conv - c0 == 2, "R6 priming read", n_conv - c0, 2);
    check(n_valid - v0 == 1, "R6 one valid", n_valid - v0, 1);
    check(n_hi - h0 == 0, "R4 no high read", n_hi - h0, 0);
  endtask

  task automatic t_parallel_burst();
    int c0 = n_conv, v0 = n_valid;
    @(negedge clk) req = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b0;
    wait_valids(v0 + 3, "R10 burst served");
    check(n_valid - v0 == 3, "R10 burst valids", n_valid - v0, 3);
    check(n_conv - c0 == 3, "R4 one read each", n_conv - c0, 3);
  endtask

  task automatic t_byte_warm();
    int c0 = n_conv, h0 = n_hi, v0 = n_valid;
    bmode = 1'b1;
    pulse_req();
    repeat (10) @(negedge clk);
    pulse_req();
    wait_valids(v0 + 2, "R10 queued mid-run");
    check(n_valid - v0 == 2, "R7 byte valids", n_valid - v0, 2);
    check(n_hi - h0 == 2, "R7 high reads", n_hi - h0, 2);
    check(n_conv - c0 == 2, "R7 converting reads", n_conv - c0, 2);
  endtask

  task automatic t_mode_hold();
    int c0 = n_conv, h0 = n_hi, v0 = n_valid;
    bmode = 1'b1;
    pulse_req();
    repeat (2) @(negedge clk);
    bmode = 1'b0;
    wait_valids(v0 + 1, "R11 sample done");
    check(n_hi - h0 == 1, "R11 mode kept", n_hi - h0, 1);
    check(n_conv - c0 == 1, "R11 one converting read", n_conv - c0, 1);
    h0 = n_hi; c0 = n_conv;
    pulse_req();
    wait_valids(v0 + 2, "R11 next sample");
    check(n_hi - h0 == 0, "R11 new mode at idle", n_hi - h0, 0);
    check(n_conv - c0 == 1, "R4 parallel read", n_conv - c0, 1);
  endtask

  task automatic t_byte_cold();
    int c0, h0, v0;
    do_reset(1'b1);
    c0 = n_conv; h0 = n_hi; v0 = n_valid;
    pulse_req();
    wait_valids(v0 + 1, "R8 cold byte served");
    check(first_seen && !first_hben, "R8 first read converts", int'(first_hben), 0);
    check(n_conv - c0 == 2, "R8 converting reads", n_conv - c0, 2);
    check(n_hi - h0 == 1, "R8 high read", n_hi - h0, 1);
    check(n_valid - v0 == 1, "R8 one valid", n_valid - v0, 1);
  endtask

  initial begin
    do_reset(1'b0);
    t_parallel_cold();
    t_parallel_burst();
    t_byte_warm();
    t_mode_hold();
    t_byte_cold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule